// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block decides which interrupt one UART channel raises and what the interrupt status register reports. The receive path supplies its FIFO fill level, a character-timeout pulse and per-character error pulses. The transmit path supplies a level that is high while its holding stage is empty. The modem-line monitor supplies one-cycle change pulses for the four modem inputs. The register file supplies the enable bits, the FIFO enable and the trigger select, plus one-cycle strobes for reads of the status, line-status, modem-status and receive-data registers.

Sources are latched where the reporting discipline needs it. Line errors and modem changes stay latched until their status register is read. Transmit-empty stays latched until the status register is read while it is the reported source. A fixed four-level priority picks the single source that is reported. The result is registered, so the status code and the interrupt line always agree with each other and with what a read strobe acts on.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset `isr_code` is 4'b0001, `irq` is low, and both `lsr_err` and `msr_delta` are zero.
- R2: Status codes are: none 4'b0001, line error 4'b0110, receive data at trigger 4'b0100, character timeout 4'b1100, transmit empty 4'b0010, modem change 4'b0000. `irq` is high exactly when bit 0 of the code is 0. A flag or strobe input shows on `isr_code`/`irq` after the second rising clock edge.
- R3: The priority from high to low is: line error, then receive (data at trigger before timeout), then transmit empty, then modem change. Only the highest pending enabled source is reported.
- R4: Receive-data and timeout interrupts are reported only when `fifo_en` is 1 and `ier` bit 0 is 1.
- R5: `trig_sel` values 00, 01, 10 and 11 set thresholds of 1, 4, 8 and 14 bytes. The receive-data source is pending while `rx_level` is at or above the selected threshold.
- R6: An `rx_timeout` pulse while `rx_level` is nonzero latches a timeout. A `rd_rhr` strobe clears it, and so does `rx_level` reaching 0.
- R7: Each `line_err` pulse bit sets the matching `lsr_err` bit. A `rd_lsr` strobe clears them all. A bit pulsed in the same cycle as `rd_lsr` stays set.
- R8: Each `modem_delta` pulse bit sets the matching `msr_delta` bit. A modem interrupt is pending while any of these bits is set. A `rd_msr` strobe clears them.
- R9: Transmit-empty becomes pending on a rising `tx_empty`, or when `ier` bit 1 rises while `tx_empty` is high. It is cleared by `tx_empty` going low. It is also cleared by `rd_isr`, but only while `isr_code` is 4'b0010.
- R10: `ier` bits 2, 1 and 3 gate the line, transmit and modem sources. A masked source is not reported, but its latched state persists and is reported once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 4 | Enables: bit0 receive, bit1 transmit empty, bit2 line error, bit3 modem |
| fifo_en | input | 1 | Receive FIFO mode enable |
| trig_sel | input | 2 | Receive threshold select |
| rx_level | input | 5 | Receive FIFO occupancy in bytes |
| rx_timeout | input | 1 | Character-timeout pulse |
| line_err | input | 4 | Line error pulses (one bit per error kind) |
| tx_empty | input | 1 | Transmit holding stage empty |
| modem_delta | input | 4 | Modem-line change pulses |
| rd_isr | input | 1 | Status register read strobe |
| rd_lsr | input | 1 | Line status read strobe |
| rd_msr | input | 1 | Modem status read strobe |
| rd_rhr | input | 1 | Receive data read strobe |
| irq | output | 1 | Interrupt request, active high |
| isr_code | output | 4 | Reported status code |
| lsr_err | output | 4 | Latched line error bits |
| msr_delta | output | 4 | Latched modem change bits |

## Verification
A wrong latch state shows up on `lsr_err`, `msr_delta` or `isr_code` after the second edge following the stimulus. A lost clear leaves a lower-priority source hidden behind a stale code, and this persists until the next read of the matching register. A wrong clear lets the next source appear one read early. The bench therefore walks every source through set, mask, unmask and clear, stacking all of them at once, so that any ordering fault is seen as a wrong code within two cycles.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  localparam int IEN_W     = 4;
  localparam int IEN_RX    = 0;
  localparam int IEN_TX    = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;

  localparam int N_TRIG = 4;
  localparam int SEL_W  = $clog2(N_TRIG);

  typedef enum logic [3:0] {
    ISR_NONE  = 4'b0001,
    ISR_LINE  = 4'b0110,
    ISR_RXAV  = 4'b0100,
    ISR_RXTO  = 4'b1100,
    ISR_TXE   = 4'b0010,
    ISR_MODEM = 4'b0000
  } isr_code_e;

  typedef struct packed {
    logic line;
    logic rxav;
    logic rxto;
    logic txe;
    logic modem;
  } pend_t;

endpackage

// File: rtl/uart_irq_rst_sync.sv
`timescale 1ns/1ps
module uart_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_l
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_l = sync_q[STAGES-1];

endmodule

// File: rtl/uart_irq_rxtrig.sv
`timescale 1ns/1ps
module uart_irq_rxtrig
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [LVL_W-1:0] rx_level,
  output logic             at_trig
);

  function automatic int thr_of(input int idx);
    case (idx)
      0:       return TRIG0;
      1:       return TRIG1;
      2:       return TRIG2;
      default: return TRIG3;
    endcase
  endfunction

  logic [N_TRIG-1:0] hit;

  // One comparator per selectable threshold; the select picks one result.
  for (genvar g = 0; g < N_TRIG; g++) begin : g_thr
    localparam int THR = thr_of(g);
    assign hit[g] = (int'(rx_level) >= THR);
  end

  assign at_trig = hit[trig_sel];

endmodule

// File: rtl/uart_irq_flags.sv
`timescale 1ns/1ps
module uart_irq_flags #(
  parameter int N_ERR = 4,
  parameter int N_DLT = 4,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_l,
  input  logic [N_ERR-1:0] line_err,
  input  logic             rd_lsr,
  input  logic [N_DLT-1:0] modem_delta,
  input  logic             rd_msr,
  input  logic             tx_empty,
  input  logic             ien_tx,
  input  logic             rd_isr,
  input  logic             isr_is_txe,
  input  logic             rx_timeout,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rd_rhr,
  output logic [N_ERR-1:0] err_q,
  output logic [N_DLT-1:0] dlt_q,
  output logic             txe_pend,
  output logic             rxto_pend
);

  // ---------------- line error latches ----------------
  logic [N_ERR-1:0] err_d;
  logic             err_en;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    assign err_d[g] = line_err[g] | (err_q[g] & ~rd_lsr);
  end
  assign err_en = rd_lsr | (|line_err);

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  // ---------------- modem change latches ----------------
  logic [N_DLT-1:0] dlt_d;
  logic             dlt_en;

  for (genvar g = 0; g < N_DLT; g++) begin : g_dlt
    assign dlt_d[g] = modem_delta[g] | (dlt_q[g] & ~rd_msr);
  end
  assign dlt_en = rd_msr | (|modem_delta);

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)      dlt_q <= '0;
    else if (dlt_en) dlt_q <= dlt_d;
  end

  // ---------------- transmit empty ----------------
  logic tx_q, ien_q;
  logic txe_set, txe_clr, txe_d;

  always_comb begin
    txe_set = tx_empty & (~tx_q | (ien_tx & ~ien_q));
    txe_clr = ~tx_empty | (rd_isr & isr_is_txe);
    txe_d   = txe_set | (txe_pend & ~txe_clr);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      tx_q     <= 1'b0;
      ien_q    <= 1'b0;
      txe_pend <= 1'b0;
    end else begin
      tx_q     <= tx_empty;
      ien_q    <= ien_tx;
      txe_pend <= txe_d;
    end
  end

  // ---------------- character timeout ----------------
  logic lvl_nz, rxto_d, rxto_en;

  always_comb begin
    lvl_nz  = |rx_level;
    rxto_d  = lvl_nz & (rx_timeout | (rxto_pend & ~rd_rhr));
    rxto_en = rx_timeout | rd_rhr | rxto_pend;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)       rxto_pend <= 1'b0;
    else if (rxto_en) rxto_pend <= rxto_d;
  end

  // ---------------- assertions ----------------
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_l)
    (rd_lsr && !(|line_err)) |=> (err_q == '0)); // R7

  AST_DLT_CLEAR: assert property (@(posedge clk) disable iff (!rst_l)
    (rd_msr && !(|modem_delta)) |=> (dlt_q == '0)); // R8

  AST_TXE_ACK: assert property (@(posedge clk) disable iff (!rst_l)
    (rd_isr && isr_is_txe && $stable(tx_empty) && $stable(ien_tx)) |=> !txe_pend); // R9

  AST_RXTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_l)
    (rx_level == '0) |=> !rxto_pend); // R6

endmodule

// File: rtl/uart_irq_arb.sv
`timescale 1ns/1ps
module uart_irq_arb
  import uart_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_l,
  input  pend_t     pend,
  output isr_code_e code_q,
  output logic      irq_q
);

  isr_code_e code_d;
  logic      irq_d;
  logic      upd;

  always_comb begin
    if (pend.line)       code_d = ISR_LINE;
    else if (pend.rxav)  code_d = ISR_RXAV;
    else if (pend.rxto)  code_d = ISR_RXTO;
    else if (pend.txe)   code_d = ISR_TXE;
    else if (pend.modem) code_d = ISR_MODEM;
    else                 code_d = ISR_NONE;
    irq_d = (code_d != ISR_NONE);
    upd   = (code_d != code_q) | (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      code_q <= ISR_NONE;
      irq_q  <= 1'b0;
    end else if (upd) begin
      code_q <= code_d;
      irq_q  <= irq_d;
    end
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_l)
    (code_q inside {ISR_NONE, ISR_LINE, ISR_RXAV, ISR_RXTO, ISR_TXE, ISR_MODEM})); // R2

  AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (!rst_l)
    (irq_q == !code_q[0])); // R2

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_l)
    pend.line |=> (code_q == ISR_LINE)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_l)
    (pend == '0) |=> (code_q == ISR_NONE && !irq_q)); // R2

endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int N_ERR = 4,
  parameter int N_DLT = 4,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ier,
  input  logic             fifo_en,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_timeout,
  input  logic [N_ERR-1:0] line_err,
  input  logic             tx_empty,
  input  logic [N_DLT-1:0] modem_delta,
  input  logic             rd_isr,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             rd_rhr,
  output logic             irq,
  output logic [3:0]       isr_code,
  output logic [N_ERR-1:0] lsr_err,
  output logic [N_DLT-1:0] msr_delta
);

  logic      rst_l;
  logic      at_trig;
  logic      txe_pend, rxto_pend;
  logic      rx_ok;
  pend_t     pend;
  isr_code_e code_q;
  logic      irq_q;

  uart_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_l (rst_l)
  );

  uart_irq_rxtrig #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .TRIG0 (TRIG0), .TRIG1 (TRIG1), .TRIG2 (TRIG2), .TRIG3 (TRIG3)
  ) u_trig (
    .trig_sel (trig_sel),
    .rx_level (rx_level),
    .at_trig  (at_trig)
  );

  uart_irq_flags #(
    .N_ERR (N_ERR),
    .N_DLT (N_DLT),
    .LVL_W (LVL_W)
  ) u_flags (
    .clk         (clk),
    .rst_l       (rst_l),
    .line_err    (line_err),
    .rd_lsr      (rd_lsr),
    .modem_delta (modem_delta),
    .rd_msr      (rd_msr),
    .tx_empty    (tx_empty),
    .ien_tx      (ier[IEN_TX]),
    .rd_isr      (rd_isr),
    .isr_is_txe  (code_q == ISR_TXE),
    .rx_timeout  (rx_timeout),
    .rx_level    (rx_level),
    .rd_rhr      (rd_rhr),
    .err_q       (lsr_err),
    .dlt_q       (msr_delta),
    .txe_pend    (txe_pend),
    .rxto_pend   (rxto_pend)
  );

  always_comb begin
    rx_ok      = fifo_en & ier[IEN_RX];
    pend.line  = (|lsr_err) & ier[IEN_LINE];
    pend.rxav  = rx_ok & at_trig;
    pend.rxto  = rx_ok & rxto_pend;
    pend.txe   = txe_pend & ier[IEN_TX];
    pend.modem = (|msr_delta) & ier[IEN_MODEM];
  end

  uart_irq_arb u_arb (
    .clk    (clk),
    .rst_l  (rst_l),
    .pend   (pend),
    .code_q (code_q),
    .irq_q  (irq_q)
  );

  assign isr_code = code_q;
  assign irq      = irq_q;

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_l)
    !(fifo_en && ier[IEN_RX]) |=> !(isr_code == ISR_RXAV || isr_code == ISR_RXTO)); // R4

  AST_TOP_TRIG: assert property (@(posedge clk) disable iff (!rst_l)
    (fifo_en && ier[IEN_RX] && int'(rx_level) >= TRIG3 && !(ier[IEN_LINE] && (|lsr_err)))
      |=> (isr_code == ISR_RXAV)); // R5

endmodule

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ier;
  logic       fifo_en;
  logic [1:0] trig_sel;
  logic [4:0] rx_level;
  logic       rx_timeout;
  logic [3:0] line_err;
  logic       tx_empty;
  logic [3:0] modem_delta;
  logic       rd_isr, rd_lsr, rd_msr, rd_rhr;
  logic       irq;
  logic [3:0] isr_code, lsr_err, msr_delta;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ctrl uut (
    .clk (clk), .rst_n (rst_n), .ier (ier), .fifo_en (fifo_en),
    .trig_sel (trig_sel), .rx_level (rx_level), .rx_timeout (rx_timeout),
    .line_err (line_err), .tx_empty (tx_empty), .modem_delta (modem_delta),
    .rd_isr (rd_isr), .rd_lsr (rd_lsr), .rd_msr (rd_msr), .rd_rhr (rd_rhr),
    .irq (irq), .isr_code (isr_code), .lsr_err (lsr_err), .msr_delta (msr_delta)
  );

  typedef struct {
    logic [3:0] code;
    logic       irq;
    logic [3:0] lsr;
    logic [3:0] msr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // Inputs for one step are set at a falling edge before the call; pulses
  // and strobes last one cycle; the result is due after the second rising edge.
  task automatic step(input logic [3:0] code, input logic [3:0] lsr,
                      input logic [3:0] msr, input string tag);
    exp_t e;
    @(posedge clk);
    @(negedge clk);
    rx_timeout = 1'b0; line_err = '0; modem_delta = '0;
    rd_isr = 1'b0; rd_lsr = 1'b0; rd_msr = 1'b0; rd_rhr = 1'b0;
    @(posedge clk);
    e.code = code; e.irq = (code != 4'b0001); e.lsr = lsr; e.msr = msr; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares two ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (isr_code !== e.code || irq !== e.irq || lsr_err !== e.lsr || msr_delta !== e.msr) begin
          errors++;
          $display("FAIL %s: actual code=%b irq=%b lsr=%b msr=%b expected code=%b irq=%b lsr=%b msr=%b",
                   e.tag, isr_code, irq, lsr_err, msr_delta, e.code, e.irq, e.lsr, e.msr);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=completed");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ier = '0; fifo_en = 1'b0; trig_sel = '0; rx_level = '0;
    rx_timeout = 1'b0; line_err = '0; tx_empty = 1'b0; modem_delta = '0;
    rd_isr = 1'b0; rd_lsr = 1'b0; rd_msr = 1'b0; rd_rhr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(4'b0001, 4'h0, 4'h0, "R1 reset state");

    // R5 thresholds, R4 gating
    fifo_en = 1; ier = 4'b0001; trig_sel = 2'b00; rx_level = 1;
    step(4'b0100, 0, 0, "R5 sel00 level1");
    rx_level = 0;               step(4'b0001, 0, 0, "R5 sel00 level0");
    trig_sel = 2'b01; rx_level = 3; step(4'b0001, 0, 0, "R5 sel01 level3");
    rx_level = 4;               step(4'b0100, 0, 0, "R5 sel01 level4");
    trig_sel = 2'b10; rx_level = 7; step(4'b0001, 0, 0, "R5 sel10 level7");
    rx_level = 8;               step(4'b0100, 0, 0, "R5 sel10 level8");
    trig_sel = 2'b11; rx_level = 13; step(4'b0001, 0, 0, "R5 sel11 level13");
    rx_level = 14;              step(4'b0100, 0, 0, "R5 sel11 level14");
    fifo_en = 0;                step(4'b0001, 0, 0, "R4 fifo disabled");
    fifo_en = 1; ier = 4'b0000; step(4'b0001, 0, 0, "R4 rx enable off");

    // R6 timeout
    ier = 4'b0001; rx_level = 2; rx_timeout = 1;
    step(4'b1100, 0, 0, "R6 timeout set");
    rd_rhr = 1;                 step(4'b0001, 0, 0, "R6 rhr read clears");
    rx_timeout = 1;             step(4'b1100, 0, 0, "R6 timeout again");
    rx_level = 0;               step(4'b0001, 0, 0, "R6 empty fifo clears");
    rx_level = 14; rx_timeout = 1; step(4'b0100, 0, 0, "R3 data before timeout");
    rx_level = 0;               step(4'b0001, 0, 0, "R6 both cleared");

    // R7 line errors, R10 masking
    ier = 4'b0100; line_err = 4'b0010; step(4'b0110, 4'b0010, 0, "R7 error latched");
    rd_lsr = 1;                 step(4'b0001, 0, 0, "R7 lsr read clears");
    ier = 4'b0000; line_err = 4'b0001; step(4'b0001, 4'b0001, 0, "R10 line masked");
    ier = 4'b0100;              step(4'b0110, 4'b0001, 0, "R10 line unmasked");
    rd_lsr = 1; line_err = 4'b1000; step(4'b0110, 4'b1000, 0, "R7 new error wins");
    rd_lsr = 1;                 step(4'b0001, 0, 0, "R7 final clear");

    // R8 modem
    ier = 4'b1000; modem_delta = 4'b0100; step(4'b0000, 0, 4'b0100, "R8 modem set");
    modem_delta = 4'b0001;      step(4'b0000, 0, 4'b0101, "R8 modem accumulate");
    rd_msr = 1;                 step(4'b0001, 0, 0, "R8 msr read clears");
    ier = 4'b0000; modem_delta = 4'b0010; step(4'b0001, 0, 4'b0010, "R10 modem masked");
    rd_msr = 1;                 step(4'b0001, 0, 0, "R8 masked clear");

    // R9 transmit empty
    ier = 4'b0010; tx_empty = 1; step(4'b0010, 0, 0, "R9 tx empty rise");
    rd_isr = 1;                 step(4'b0001, 0, 0, "R9 isr read acks");
    tx_empty = 0;               step(4'b0001, 0, 0, "R9 tx busy");
    tx_empty = 1;               step(4'b0010, 0, 0, "R9 tx empty again");
    tx_empty = 0;               step(4'b0001, 0, 0, "R9 refill clears");
    ier = 4'b0000; tx_empty = 1; step(4'b0001, 0, 0, "R10 tx masked");
    ier = 4'b0010;              step(4'b0010, 0, 0, "R10 tx unmasked");
    rd_isr = 1;                 step(4'b0001, 0, 0, "R9 ack");
    ier = 4'b0000;              step(4'b0001, 0, 0, "R9 disable");
    ier = 4'b0010;              step(4'b0010, 0, 0, "R9 enable while empty");
    rd_isr = 1;                 step(4'b0001, 0, 0, "R9 ack again");
    tx_empty = 0;               step(4'b0001, 0, 0, "R9 busy before stack");

    // R3 all sources stacked
    ier = 4'b1111; fifo_en = 1; trig_sel = 2'b11; rx_level = 14;
    line_err = 4'b0100; modem_delta = 4'b1000; tx_empty = 1;
    step(4'b0110, 4'b0100, 4'b1000, "R3 line highest");
    rd_isr = 1;                 step(4'b0110, 4'b0100, 4'b1000, "R9 isr read other source");
    rd_lsr = 1;                 step(4'b0100, 0, 4'b1000, "R3 rx next");
    rx_level = 0;               step(4'b0010, 0, 4'b1000, "R3 tx next");
    rd_isr = 1;                 step(4'b0000, 0, 4'b1000, "R3 modem lowest");
    rd_msr = 1;                 step(4'b0001, 0, 0, "R3 all clear");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule